// File: doc/BRIEF.md
# Descriptor return policy controller

The block decides, once a packet has been handed to a transfer engine, which descriptor pointers go back to the free queues, to which queue, at which end of that queue, and when. Per packet it takes a policy (whole-packet or per-buffer return, early or deferred return, head or tail push, and the packet's own return queue), the packet length, and the descriptors of the chain in linked order, each with the return queue held in that descriptor. Two event inputs from the transfer engine drive the timing: a pulse each time the next buffer's transfer begins, and a pulse when every read of the packet has finished.

Return requests leave on a registered valid/ready stream carrying queue number, pointer and a head-insert flag. The all-ones queue number is treated as reserved: a request aimed at it is not issued, and a one-cycle error pulse is raised instead. After the packet's final request has been accepted, or suppressed, a one-cycle done pulse marks the end of the packet and the block accepts the next one. The queue storage is not part of the block.

Top module: `drq_return_ctrl`

## Requirements
- R1: With `pol_per_buffer` low, exactly one request is issued per packet, carrying `pol_qnum` as queue and the pointer of the first descriptor of the chain.
- R2: With `pol_per_buffer` high, one request per stored descriptor is issued, in the order the descriptors were written, each carrying that descriptor's own queue number.
- R3: `rq_head` equals `pol_head` when `pol_per_buffer` is high and is 0 (tail insert) when it is low.
- R4: With `pol_early` low and a non-zero packet length, no request is issued before an `xfer_done` pulse has been seen for the packet.
- R5: With `pol_early` high and a non-zero packet length, the k-th request of the packet (k counting from 1) is not issued until k `buf_begin` pulses have been seen for the packet.
- R6: A request whose queue number is all ones (16'hFFFF at the default width) is never presented on `rq_valid`; instead `rsvd_err` pulses high for one cycle and the remaining descriptors of the chain are still processed.
- R7: With a packet length of 0, all the packet's requests are issued without any `buf_begin` or `xfer_done` pulse.
- R8: While `rq_valid` is high and `rq_ready` low, `rq_valid`, `rq_qnum`, `rq_ptr` and `rq_head` hold their values; a request is retired only in a cycle where both are high.
- R9: `pkt_done` is a one-cycle pulse, raised in the cycle after the packet's final request is accepted or suppressed, with `busy` already low; it occurs exactly once per packet.
- R10: `pkt_load` while `busy` is high is ignored; the packet in progress keeps its policy.
- R11: After reset `rq_valid`, `rsvd_err`, `pkt_done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_load | input | 1 | Start a packet; taken only while not busy |
| pol_per_buffer | input | 1 | 1: return every buffer to its own queue; 0: return the linked packet as one pointer |
| pol_early | input | 1 | 1: return each pointer as its transfer begins; 0: wait for completion |
| pol_head | input | 1 | Head insert request, used only in per-buffer mode |
| pol_qnum | input | QNUM_W | Packet return queue for whole-packet mode |
| pkt_len | input | LEN_W | Packet length in bytes; 0 means reclaim only |
| desc_wr | input | 1 | Descriptor entry strobe, taken while collecting |
| desc_ptr | input | PTR_W | Descriptor pointer |
| desc_qnum | input | QNUM_W | Return queue held in that descriptor |
| desc_last | input | 1 | Marks the final descriptor of the chain |
| buf_begin | input | 1 | Transfer of the next buffer has begun |
| xfer_done | input | 1 | All reads of the packet are complete |
| rq_valid | output | 1 | Return request valid |
| rq_ready | input | 1 | Return request accepted by the queue side |
| rq_qnum | output | QNUM_W | Target queue |
| rq_ptr | output | PTR_W | Pointer to push |
| rq_head | output | 1 | 1: push at head, 0: push at tail |
| rsvd_err | output | 1 | Pulse: a request to the reserved queue was dropped |
| pkt_done | output | 1 | Pulse: packet fully returned |
| busy | output | 1 | A packet is being collected or returned |

## Verification
A wrong sequencing state shows at the ports as a request that appears too early (before its begin or completion event), a request with the wrong queue or pointer, or a missing or doubled done pulse; the reference model flags each of these in the very cycle the outputs first diverge. A corrupted release counter is visible within one request slot as a request that is released or withheld one event off. A wrong descriptor store shows up at the latest when the affected entry is returned, by pointer or queue value.

// File: rtl/drq_pkg.sv
package drq_pkg;

  // Sequencing phases of one packet's return.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_WAIT,
    ST_READ,
    ST_SEND
  } drq_state_e;

endpackage

// File: rtl/drq_desc_ram.sv
// Simple dual-port store for the descriptor chain; registered read so that
// it maps onto block RAM.
module drq_desc_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/drq_release_gate.sv
// Counts the transfer events of the current packet and says whether the
// entry at rd_idx may be returned now.
module drq_release_gate #(
  parameter int MAX_DESC = 16,
  parameter int CNT_W    = $clog2(MAX_DESC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             active,
  input  logic             buf_begin,
  input  logic             xfer_done,
  input  logic             early,
  input  logic             zero_len,
  input  logic [CNT_W-1:0] rd_idx,
  output logic             release_ok
);

  localparam logic [CNT_W-1:0] BEGIN_MAX = CNT_W'(MAX_DESC);

  logic [CNT_W-1:0] began;
  logic             fin;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      began <= '0;
      fin   <= 1'b0;
    end else if (active) begin
      if (buf_begin && (began < BEGIN_MAX)) began <= began + 1'b1;
      if (xfer_done) fin <= 1'b1;
    end
  end

  assign release_ok = zero_len || (early ? (rd_idx < began) : fin);

endmodule

// File: rtl/drq_issue.sv
// Packet sequencer: captures the policy, stores the chain, then walks it and
// drives the registered return-request stream.
module drq_issue
  import drq_pkg::*;
#(
  parameter int PTR_W    = 48,
  parameter int QNUM_W   = 16,
  parameter int LEN_W    = 22,
  parameter int MAX_DESC = 16,
  parameter int IDX_W    = $clog2(MAX_DESC),
  parameter int CNT_W    = $clog2(MAX_DESC + 1),
  parameter int ENT_W    = PTR_W + QNUM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_load,
  input  logic              pol_per_buffer,
  input  logic              pol_early,
  input  logic              pol_head,
  input  logic [QNUM_W-1:0] pol_qnum,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              desc_wr,
  input  logic [PTR_W-1:0]  desc_ptr,
  input  logic [QNUM_W-1:0] desc_qnum,
  input  logic              desc_last,
  input  logic              release_ok,
  input  logic              rq_ready,
  input  logic [ENT_W-1:0]  ram_rdata,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_waddr,
  output logic [ENT_W-1:0]  ram_wdata,
  output logic              ram_re,
  output logic [IDX_W-1:0]  ram_raddr,
  output logic              load_acc,
  output logic              early,
  output logic              zero_len,
  output logic [CNT_W-1:0]  rd_idx,
  output logic              rq_valid,
  output logic [QNUM_W-1:0] rq_qnum,
  output logic [PTR_W-1:0]  rq_ptr,
  output logic              rq_head,
  output logic              rsvd_err,
  output logic              pkt_done,
  output logic              busy
);

  localparam logic [QNUM_W-1:0] RSVD_Q   = '1;
  localparam logic [CNT_W-1:0]  DESC_CAP = CNT_W'(MAX_DESC);

  drq_state_e        st;
  logic              per_buf_q;
  logic              early_q;
  logic              head_q;
  logic [QNUM_W-1:0] pkt_q;
  logic              len0_q;
  logic [CNT_W-1:0]  n_desc;

  logic [QNUM_W-1:0] ent_q;
  logic [PTR_W-1:0]  ent_p;
  logic [QNUM_W-1:0] sel_q;
  logic              is_last;

  assign {ent_q, ent_p} = ram_rdata;
  assign sel_q   = per_buf_q ? ent_q : pkt_q;
  assign is_last = !per_buf_q || (rd_idx == (n_desc - 1'b1));

  assign busy     = (st != ST_IDLE);
  assign load_acc = pkt_load && (st == ST_IDLE);
  assign early    = early_q;
  assign zero_len = len0_q;

  assign ram_we    = (st == ST_COLLECT) && desc_wr && (n_desc < DESC_CAP);
  assign ram_waddr = n_desc[IDX_W-1:0];
  assign ram_wdata = {desc_qnum, desc_ptr};
  assign ram_re    = (st == ST_WAIT) && release_ok;
  assign ram_raddr = rd_idx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      per_buf_q <= 1'b0;
      early_q   <= 1'b0;
      head_q    <= 1'b0;
      pkt_q     <= '0;
      len0_q    <= 1'b0;
      n_desc    <= '0;
      rd_idx    <= '0;
      rq_valid  <= 1'b0;
      rq_qnum   <= '0;
      rq_ptr    <= '0;
      rq_head   <= 1'b0;
      rsvd_err  <= 1'b0;
      pkt_done  <= 1'b0;
    end else begin
      rsvd_err <= 1'b0;
      pkt_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (pkt_load) begin
            per_buf_q <= pol_per_buffer;
            early_q   <= pol_early;
            head_q    <= pol_head;
            pkt_q     <= pol_qnum;
            len0_q    <= (pkt_len == '0);
            n_desc    <= '0;
            rd_idx    <= '0;
            st        <= ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (desc_wr) begin
            if (ram_we)    n_desc <= n_desc + 1'b1;
            if (desc_last) st     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (release_ok) st <= ST_READ;
        end
        ST_READ: begin
          if (sel_q == RSVD_Q) begin
            rsvd_err <= 1'b1;
            if (is_last) begin
              pkt_done <= 1'b1;
              st       <= ST_IDLE;
            end else begin
              rd_idx <= rd_idx + 1'b1;
              st     <= ST_WAIT;
            end
          end else begin
            rq_valid <= 1'b1;
            rq_qnum  <= sel_q;
            rq_ptr   <= ent_p;
            rq_head  <= per_buf_q && head_q;
            st       <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (rq_ready) begin
            rq_valid <= 1'b0;
            if (is_last) begin
              pkt_done <= 1'b1;
              st       <= ST_IDLE;
            end else begin
              rd_idx <= rd_idx + 1'b1;
              st     <= ST_WAIT;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/drq_return_ctrl.sv
module drq_return_ctrl #(
  parameter int PTR_W    = 48,
  parameter int QNUM_W   = 16,
  parameter int LEN_W    = 22,
  parameter int MAX_DESC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_load,
  input  logic              pol_per_buffer,
  input  logic              pol_early,
  input  logic              pol_head,
  input  logic [QNUM_W-1:0] pol_qnum,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              desc_wr,
  input  logic [PTR_W-1:0]  desc_ptr,
  input  logic [QNUM_W-1:0] desc_qnum,
  input  logic              desc_last,
  input  logic              buf_begin,
  input  logic              xfer_done,
  output logic              rq_valid,
  input  logic              rq_ready,
  output logic [QNUM_W-1:0] rq_qnum,
  output logic [PTR_W-1:0]  rq_ptr,
  output logic              rq_head,
  output logic              rsvd_err,
  output logic              pkt_done,
  output logic              busy
);

  localparam int IDX_W = $clog2(MAX_DESC);
  localparam int CNT_W = $clog2(MAX_DESC + 1);
  localparam int ENT_W = PTR_W + QNUM_W;

  logic             ram_we, ram_re;
  logic [IDX_W-1:0] ram_waddr, ram_raddr;
  logic [ENT_W-1:0] ram_wdata, ram_rdata;
  logic             load_acc, early, zero_len, release_ok;
  logic [CNT_W-1:0] rd_idx;

  drq_desc_ram #(
    .DEPTH (MAX_DESC),
    .WIDTH (ENT_W),
    .AW    (IDX_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  drq_release_gate #(
    .MAX_DESC (MAX_DESC),
    .CNT_W    (CNT_W)
  ) u_gate (
    .clk        (clk),
    .rst        (rst),
    .clear      (load_acc),
    .active     (busy),
    .buf_begin  (buf_begin),
    .xfer_done  (xfer_done),
    .early      (early),
    .zero_len   (zero_len),
    .rd_idx     (rd_idx),
    .release_ok (release_ok)
  );

  drq_issue #(
    .PTR_W    (PTR_W),
    .QNUM_W   (QNUM_W),
    .LEN_W    (LEN_W),
    .MAX_DESC (MAX_DESC),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W),
    .ENT_W    (ENT_W)
  ) u_issue (
    .clk            (clk),
    .rst            (rst),
    .pkt_load       (pkt_load),
    .pol_per_buffer (pol_per_buffer),
    .pol_early      (pol_early),
    .pol_head       (pol_head),
    .pol_qnum       (pol_qnum),
    .pkt_len        (pkt_len),
    .desc_wr        (desc_wr),
    .desc_ptr       (desc_ptr),
    .desc_qnum      (desc_qnum),
    .desc_last      (desc_last),
    .release_ok     (release_ok),
    .rq_ready       (rq_ready),
    .ram_rdata      (ram_rdata),
    .ram_we         (ram_we),
    .ram_waddr      (ram_waddr),
    .ram_wdata      (ram_wdata),
    .ram_re         (ram_re),
    .ram_raddr      (ram_raddr),
    .load_acc       (load_acc),
    .early          (early),
    .zero_len       (zero_len),
    .rd_idx         (rd_idx),
    .rq_valid       (rq_valid),
    .rq_qnum        (rq_qnum),
    .rq_ptr         (rq_ptr),
    .rq_head        (rq_head),
    .rsvd_err       (rsvd_err),
    .pkt_done       (pkt_done),
    .busy           (busy)
  );

endmodule

// File: rtl/drq_return_ctrl_chk.sv
module drq_return_ctrl_chk #(
  parameter int PTR_W  = 48,
  parameter int QNUM_W = 16,
  parameter int LEN_W  = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              pkt_load,
  input logic              pol_per_buffer,
  input logic              pol_early,
  input logic              pol_head,
  input logic [LEN_W-1:0]  pkt_len,
  input logic              xfer_done,
  input logic              rq_valid,
  input logic              rq_ready,
  input logic [QNUM_W-1:0] rq_qnum,
  input logic [PTR_W-1:0]  rq_ptr,
  input logic              rq_head,
  input logic              rsvd_err,
  input logic              pkt_done,
  input logic              busy
);

  // Policy and completion as seen at the ports for the packet in flight.
  logic c_per_buf, c_early, c_head, c_len0, c_fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_per_buf <= 1'b0;
      c_early   <= 1'b0;
      c_head    <= 1'b0;
      c_len0    <= 1'b0;
      c_fin     <= 1'b0;
    end else if (pkt_load && !busy) begin
      c_per_buf <= pol_per_buffer;
      c_early   <= pol_early;
      c_head    <= pol_head;
      c_len0    <= (pkt_len == '0);
      c_fin     <= 1'b0;
    end else if (busy && xfer_done) begin
      c_fin <= 1'b1;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_qnum) && $stable(rq_ptr) && $stable(rq_head));

  p_no_rsvd_r6: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> (rq_qnum != {QNUM_W{1'b1}}));

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rsvd_err |=> !rsvd_err);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> !busy && !rq_valid);

  p_done_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_done) |-> rsvd_err || $past(rq_valid && rq_ready));

  p_tail_whole_r3: assert property (@(posedge clk) disable iff (rst)
    rq_valid && !c_per_buf |-> !rq_head);

  p_head_buf_r3: assert property (@(posedge clk) disable iff (rst)
    rq_valid && c_per_buf |-> (rq_head == c_head));

  p_wait_fin_r4: assert property (@(posedge clk) disable iff (rst)
    rq_valid && !c_early && !c_len0 |-> c_fin);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rq_valid);

endmodule

bind drq_return_ctrl drq_return_ctrl_chk #(
  .PTR_W  (PTR_W),
  .QNUM_W (QNUM_W),
  .LEN_W  (LEN_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .pkt_load       (pkt_load),
  .pol_per_buffer (pol_per_buffer),
  .pol_early      (pol_early),
  .pol_head       (pol_head),
  .pkt_len        (pkt_len),
  .xfer_done      (xfer_done),
  .rq_valid       (rq_valid),
  .rq_ready       (rq_ready),
  .rq_qnum        (rq_qnum),
  .rq_ptr         (rq_ptr),
  .rq_head        (rq_head),
  .rsvd_err       (rsvd_err),
  .pkt_done       (pkt_done),
  .busy           (busy)
);

// File: tb/drq_return_ctrl_tb.sv
module drq_return_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PTR_W      = 48;
  localparam int QNUM_W     = 16;
  localparam int LEN_W      = 22;
  localparam int MAX_DESC   = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pkt_load = 1'b0;
  logic              pol_per_buffer = 1'b0, pol_early = 1'b0, pol_head = 1'b0;
  logic [QNUM_W-1:0] pol_qnum = '0;
  logic [LEN_W-1:0]  pkt_len = '0;
  logic              desc_wr = 1'b0, desc_last = 1'b0;
  logic [PTR_W-1:0]  desc_ptr = '0;
  logic [QNUM_W-1:0] desc_qnum = '0;
  logic              buf_begin = 1'b0, xfer_done = 1'b0;
  logic              rq_ready = 1'b1;
  logic              rq_valid, rq_head, rsvd_err, pkt_done, busy;
  logic [QNUM_W-1:0] rq_qnum;
  logic [PTR_W-1:0]  rq_ptr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  drq_return_ctrl #(
    .PTR_W (PTR_W), .QNUM_W (QNUM_W), .LEN_W (LEN_W), .MAX_DESC (MAX_DESC)
  ) u_dut (
    .clk (clk), .rst (rst), .pkt_load (pkt_load),
    .pol_per_buffer (pol_per_buffer), .pol_early (pol_early),
    .pol_head (pol_head), .pol_qnum (pol_qnum), .pkt_len (pkt_len),
    .desc_wr (desc_wr), .desc_ptr (desc_ptr), .desc_qnum (desc_qnum),
    .desc_last (desc_last), .buf_begin (buf_begin), .xfer_done (xfer_done),
    .rq_valid (rq_valid), .rq_ready (rq_ready), .rq_qnum (rq_qnum),
    .rq_ptr (rq_ptr), .rq_head (rq_head), .rsvd_err (rsvd_err),
    .pkt_done (pkt_done), .busy (busy)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { logic [PTR_W-1:0] p; logic [QNUM_W-1:0] q; } ent_t;
  ent_t              mq[$];
  int                ph = 0;        // 0 idle, 1 collect, 2 wait, 3 fetch, 4 offer
  int                cred = 0, idx = 0;
  bit                fin = 0, m_perbuf = 0, m_early = 0, m_head = 0, m_len0 = 0;
  logic [QNUM_W-1:0] m_pq = '0;
  bit                m_valid = 0, m_err = 0, m_done = 0, m_h = 0;
  logic [QNUM_W-1:0] m_q = '0;
  logic [PTR_W-1:0]  m_p = '0;

  function automatic bit at_end();
    return !m_perbuf || (idx == mq.size() - 1);
  endfunction

  always @(posedge clk) begin
    int old_ph;
    old_ph = ph;
    m_err  = 0;
    m_done = 0;
    if (rst) begin
      ph = 0; m_valid = 0; cred = 0; fin = 0; idx = 0;
    end else begin
      case (ph)
        0: if (pkt_load) begin
          m_perbuf = pol_per_buffer; m_early = pol_early; m_head = pol_head;
          m_pq = pol_qnum; m_len0 = (pkt_len == 0);
          mq.delete(); idx = 0; ph = 1;
        end
        1: if (desc_wr) begin
          if (mq.size() < MAX_DESC) mq.push_back('{p: desc_ptr, q: desc_qnum});
          if (desc_last) ph = 2;
        end
        2: if (m_len0 || (m_early ? (idx < cred) : fin)) ph = 3;
        3: begin
          logic [QNUM_W-1:0] tq;
          tq = m_perbuf ? mq[idx].q : m_pq;
          if (tq == '1) begin
            m_err = 1;
            if (at_end()) begin m_done = 1; ph = 0; end else begin idx++; ph = 2; end
          end else begin
            m_valid = 1; m_q = tq; m_p = mq[idx].p; m_h = m_perbuf && m_head; ph = 4;
          end
        end
        4: if (rq_ready) begin
          m_valid = 0;
          if (at_end()) begin m_done = 1; ph = 0; end else begin idx++; ph = 2; end
        end
        default: ph = 0;
      endcase
      if (old_ph == 0 && ph == 1) begin cred = 0; fin = 0; end
      else if (old_ph != 0) begin
        if (buf_begin && cred < MAX_DESC) cred++;
        if (xfer_done) fin = 1;
      end
    end
  end

  // Cycle compare, away from the active edge (R8, R9, R6 timing).
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R8 rq_valid vs model", 64'(rq_valid), 64'(m_valid));
      if (m_valid) begin
        check("R2 rq_qnum vs model", 64'(rq_qnum), 64'(m_q));
        check("R2 rq_ptr vs model",  64'(rq_ptr),  64'(m_p));
        check("R3 rq_head vs model", 64'(rq_head), 64'(m_h));
      end
      check("R6 rsvd_err vs model", 64'(rsvd_err), 64'(m_err));
      check("R9 pkt_done vs model", 64'(pkt_done), 64'(m_done));
      check("R10 busy vs model",    64'(busy),     64'(ph != 0));
    end
  end

  // Accepted-request log and pulse counters.
  ent_t got[$];
  bit   got_h[$];
  int   err_cnt = 0, done_cnt = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (rq_valid && rq_ready) begin
        got.push_back('{p: rq_ptr, q: rq_qnum});
        got_h.push_back(rq_head);
      end
      if (rsvd_err) err_cnt++;
      if (pkt_done) done_cnt++;
    end
  end

  // Backpressure pattern on rq_ready.
  bit bp = 0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    rq_ready <= !bp || (cyc % 3 == 0);
  end

  // ---------------- stimulus helpers ----------------
  task automatic load(input bit pb, input bit er, input bit hd,
                      input logic [QNUM_W-1:0] q, input logic [LEN_W-1:0] len);
    @(negedge clk);
    pkt_load = 1; pol_per_buffer = pb; pol_early = er; pol_head = hd;
    pol_qnum = q; pkt_len = len;
    @(negedge clk);
    pkt_load = 0;
  endtask

  task automatic put(input logic [PTR_W-1:0] p, input logic [QNUM_W-1:0] q, input bit last);
    desc_wr = 1; desc_ptr = p; desc_qnum = q; desc_last = last;
    @(negedge clk);
    desc_wr = 0; desc_last = 0;
  endtask

  task automatic pulse_begin();
    buf_begin = 1; @(negedge clk); buf_begin = 0;
  endtask

  task automatic pulse_fin();
    xfer_done = 1; @(negedge clk); xfer_done = 0;
  endtask

  task automatic wait_pkt();
    int start;
    start = done_cnt;
    while (done_cnt == start) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_log();
    got.delete(); got_h.delete(); err_cnt = 0; done_cnt = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 rq_valid", 64'(rq_valid), 0);
    check("R11 busy",     64'(busy),     0);
    check("R11 pkt_done", 64'(pkt_done), 0);
    check("R11 rsvd_err", 64'(rsvd_err), 0);
    rst = 0;
    @(negedge clk);

    // R1, R3, R4: whole packet, deferred, head bit set but ignored
    clear_log();
    load(0, 0, 1, 16'h0012, 22'd100);
    put(48'hA000, 16'h0005, 0);
    put(48'hA040, 16'h0006, 0);
    put(48'hA080, 16'h0007, 1);
    pulse_begin();
    repeat (6) @(negedge clk);
    check("R4 nothing before completion", 64'(got.size()), 0);
    pulse_fin();
    wait_pkt();
    check("R1 one request", 64'(got.size()), 1);
    if (got.size() == 1) begin
      check("R1 packet queue", 64'(got[0].q), 64'h12);
      check("R1 first pointer", 64'(got[0].p), 64'hA000);
      check("R3 whole mode tail", 64'(got_h[0]), 0);
    end
    check("R9 one done", 64'(done_cnt), 1);

    // R2, R3, R8: per buffer, tail, with backpressure
    clear_log();
    bp = 1;
    load(1, 0, 0, 16'h0099, 22'd2000);
    for (int i = 0; i < 4; i++) put(48'hB000 + 48'(i * 16), 16'(i + 1), i == 3);
    pulse_fin();
    wait_pkt();
    bp = 0;
    check("R2 count", 64'(got.size()), 4);
    for (int i = 0; i < 4; i++) if (i < got.size()) begin
      check("R2 order ptr", 64'(got[i].p), 64'(48'hB000 + 48'(i * 16)));
      check("R2 own queue", 64'(got[i].q), 64'(i + 1));
      check("R3 tail", 64'(got_h[i]), 0);
    end

    // R5, R3: per buffer, early, head
    clear_log();
    load(1, 1, 1, 16'h0001, 22'd300);
    for (int i = 0; i < 3; i++) put(48'hC000 + 48'(i * 32), 16'(16'h20 + i), i == 2);
    repeat (5) @(negedge clk);
    check("R5 none before begin", 64'(got.size()), 0);
    pulse_begin();
    repeat (6) @(negedge clk);
    check("R5 one after one begin", 64'(got.size()), 1);
    pulse_begin();
    pulse_begin();
    wait_pkt();
    check("R5 all after three begins", 64'(got.size()), 3);
    for (int i = 0; i < 3; i++) if (i < got.size()) begin
      check("R5 early order", 64'(got[i].p), 64'(48'hC000 + 48'(i * 32)));
      check("R3 head", 64'(got_h[i]), 1);
    end

    // R7: zero length reclaims without events
    clear_log();
    load(1, 0, 0, 16'h0001, 22'd0);
    put(48'hD000, 16'h0031, 0);
    put(48'hD100, 16'h0032, 1);
    wait_pkt();
    check("R7 returns without events", 64'(got.size()), 2);

    // R6: reserved queue in the middle of a chain
    clear_log();
    load(1, 0, 0, 16'h0001, 22'd64);
    put(48'hE000, 16'h0041, 0);
    put(48'hE100, 16'hFFFF, 0);
    put(48'hE200, 16'h0043, 1);
    pulse_fin();
    wait_pkt();
    check("R6 suppressed count", 64'(got.size()), 2);
    check("R6 one error pulse", 64'(err_cnt), 1);
    if (got.size() == 2) check("R6 chain continues", 64'(got[1].p), 64'hE200);

    // R6, R9: reserved packet queue in whole mode
    clear_log();
    load(0, 0, 0, 16'hFFFF, 22'd64);
    put(48'hF000, 16'h0001, 1);
    pulse_fin();
    wait_pkt();
    check("R6 whole suppressed", 64'(got.size()), 0);
    check("R6 whole error", 64'(err_cnt), 1);
    check("R9 done after suppression", 64'(done_cnt), 1);

    // R10: load while busy is ignored
    clear_log();
    load(0, 0, 0, 16'h0033, 22'd10);
    load(1, 1, 1, 16'h0044, 22'd0);
    put(48'h1000, 16'h0055, 0);
    put(48'h1100, 16'h0056, 1);
    repeat (4) @(negedge clk);
    check("R10 second load ignored (no early return)", 64'(got.size()), 0);
    pulse_fin();
    wait_pkt();
    check("R10 count", 64'(got.size()), 1);
    if (got.size() == 1) check("R10 first policy queue", 64'(got[0].q), 64'h33);
    check("R9 idle after packet", 64'(busy), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule